// File: doc/BRIEF.md
# Dual-Bank Pulse-Swallow Synthesizer Divider Pair

This block holds the two counters of an integer-N frequency synthesizer. The feedback path divides the oscillator clock by a 14-bit ratio. It does this with a dual-modulus scheme: a prescaler that divides by 16 or by 17, a 4-bit swallow count and a 10-bit main count. The prescaler is modelled inside the block, and the modulus request it obeys is also brought out as an output. The reference path is an 11-bit programmable counter. Each path emits a one-cycle comparison pulse once per output period, for use by a phase detector that sits outside this block.

Two banks of ratios are kept, each holding one feedback ratio and one reference ratio. A select input picks the bank that each path loads at the start of its next period, so a retune never cuts a period short. New ratios arrive on a parallel write port. A field that lies outside its legal range is dropped without touching the stored value. In this project both paths advance on the single block clock.

Top module: `synth_div_pair`

## Requirements
- R1: The feedback pulse `fb_pulse` is high for exactly one cycle in every period of M cycles, where M = 16·P + A, P is bits 13:4 of the active feedback ratio and A is bits 3:0. Consecutive periods follow with no lost or extra cycle.
- R2: `mod_ctl` is high during the first 17·A cycles of each feedback period and low during the remaining 16·(P − A) cycles.
- R3: The reference pulse `ref_pulse` is high for exactly one cycle in every period of R cycles, where R is the active reference ratio.
- R4: When `bank_sel` is 1, bank one supplies the next period's ratios. When it is 0, bank two supplies them.
- R5: A change of `bank_sel` or of a stored ratio takes effect only when the affected path starts its next period. The running period keeps its length.
- R6: A cycle with `wr_en` high writes into the bank named by `wr_bank` (1 = bank one, 0 = bank two). The feedback field is stored only if it lies in 256..16383, and the reference field only if it lies in 2..2047. An out-of-range field leaves its stored value unchanged and does not block the other field.
- R7: Synchronous active-high `rst` does four things. It sets bank one to M = 10519, R = 492 and bank two to M = 4269, R = 492. It clears both counters and holds both pulses low. It loads the defaults of the bank chosen by `bank_sel` as the active ratios, so the first pulses appear M and R cycles after the first cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; both dividers advance on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bank_sel | input | 1 | 1 selects bank one, 0 selects bank two |
| wr_en | input | 1 | Write strobe for the ratio banks |
| wr_bank | input | 1 | Bank addressed by a write (1 = bank one) |
| wr_fb_ratio | input | 14 | Feedback ratio to store (main count in 13:4, swallow count in 3:0) |
| wr_ref_ratio | input | 11 | Reference ratio to store |
| fb_pulse | output | 1 | One-cycle pulse per feedback period |
| ref_pulse | output | 1 | One-cycle pulse per reference period |
| mod_ctl | output | 1 | Prescaler modulus request, high for divide-by-17 |

## Verification
A wrong swallow or prescaler state shows first on `mod_ctl`, which a per-cycle comparison catches within one prescaler cycle. If the error only shifts the period boundary, it shows at the latest on the next `fb_pulse`, which lands in the wrong cycle. A wrong reference counter or a wrongly latched bank moves `ref_pulse` or `fb_pulse` off its expected cycle within one period of the affected path. The stimulus therefore includes bank switches and writes issued in the middle of a period. A dropped or wrongly accepted out-of-range write changes the length of the following period, so it is visible at the ports one full period later.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

    localparam int SW_W    = 4;
    localparam int MAIN_W  = 10;
    localparam int FB_W    = SW_W + MAIN_W;
    localparam int REF_W   = 11;
    localparam int MOD_LO  = 1 << SW_W;
    localparam int FB_MIN  = MOD_LO * MOD_LO;
    localparam int REF_MIN = 2;

    localparam int FB_DEF_ONE  = 10519;
    localparam int FB_DEF_TWO  = 4269;
    localparam int REF_DEF_ONE = 492;
    localparam int REF_DEF_TWO = 492;

    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [SW_W-1:0]   swal;
    } fb_ratio_t;

    typedef struct packed {
        fb_ratio_t          fb;
        logic [REF_W-1:0]   refr;
    } bank_t;

    typedef enum logic {
        BANK_TWO = 1'b0,
        BANK_ONE = 1'b1
    } bank_id_t;

    function automatic logic fb_legal(input logic [FB_W-1:0] v);
        return int'(v) >= FB_MIN;
    endfunction

    function automatic logic ref_legal(input logic [REF_W-1:0] v);
        return int'(v) >= REF_MIN;
    endfunction

    function automatic bank_t default_bank(input bank_id_t id);
        bank_t b;
        if (id == BANK_ONE) begin
            b.fb   = fb_ratio_t'(FB_W'(FB_DEF_ONE));
            b.refr = REF_W'(REF_DEF_ONE);
        end else begin
            b.fb   = fb_ratio_t'(FB_W'(FB_DEF_TWO));
            b.refr = REF_W'(REF_DEF_TWO);
        end
        return b;
    endfunction

endpackage

// File: rtl/synth_div_banks.sv
module synth_div_banks
    import synth_div_pkg::*;
#(
    parameter int NUM_BANKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [FB_W-1:0]   wr_fb,
    input  logic [REF_W-1:0]  wr_ref,
    input  logic              sel,
    output bank_t             sel_bank
);

    bank_t [NUM_BANKS-1:0] banks_q;

    always_ff @(posedge clk) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rst) begin
                banks_q[b] <= default_bank(bank_id_t'(b[0]));
            end else if (wr_en && (int'(wr_bank) == b)) begin
                if (fb_legal(wr_fb))
                    banks_q[b].fb <= fb_ratio_t'(wr_fb);
                if (ref_legal(wr_ref))
                    banks_q[b].refr <= wr_ref;
            end
        end
    end

    assign sel_bank = banks_q[sel];

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
            // R6: a stored ratio never leaves its legal range
            assert_bank_legal_R6: assert property (@(posedge clk) disable iff (rst)
                (int'(banks_q[g].fb) >= FB_MIN) && (int'(banks_q[g].refr) >= REF_MIN));
        end
    endgenerate

endmodule

// File: rtl/synth_fb_div.sv
module synth_fb_div
    import synth_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fb_ratio_t  next_ratio,
    input  fb_ratio_t  reset_ratio,
    output logic       term_pulse,
    output logic       mod_hi
);

    localparam logic [SW_W:0] PRE_LAST_LO = (SW_W+1)'(MOD_LO - 1);
    localparam logic [SW_W:0] PRE_LAST_HI = (SW_W+1)'(MOD_LO);

    fb_ratio_t          act_q;
    logic [SW_W:0]      pre_cnt_q;
    logic [MAIN_W-1:0]  main_cnt_q;
    logic [MAIN_W-1:0]  swal_ext;
    logic [MAIN_W-1:0]  main_last;
    logic               pre_end;
    logic               period_end;

    // prescaler modulus request: 17 while swallow cycles remain
    assign swal_ext   = {{(MAIN_W-SW_W){1'b0}}, act_q.swal};
    assign mod_hi     = (main_cnt_q < swal_ext);
    assign pre_end    = (pre_cnt_q == (mod_hi ? PRE_LAST_HI : PRE_LAST_LO));
    assign main_last  = act_q.main - 1'b1;
    assign period_end = pre_end && (main_cnt_q == main_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q      <= reset_ratio;
            pre_cnt_q  <= '0;
            main_cnt_q <= '0;
            term_pulse <= 1'b0;
        end else begin
            term_pulse <= period_end;
            pre_cnt_q  <= pre_end ? '0 : pre_cnt_q + 1'b1;
            if (pre_end)
                main_cnt_q <= period_end ? '0 : main_cnt_q + 1'b1;
            if (period_end)
                act_q <= next_ratio;
        end
    end

    // R1: the feedback pulse lasts one cycle
    assert_fb_single_R1: assert property (@(posedge clk) disable iff (rst)
        term_pulse |=> !term_pulse);

    // R1: the main count stays inside the active main ratio
    assert_main_bound_R1: assert property (@(posedge clk) disable iff (rst)
        main_cnt_q < act_q.main);

    // R2: the prescaler never counts beyond divide-by-17
    assert_pre_bound_R2: assert property (@(posedge clk) disable iff (rst)
        pre_cnt_q <= PRE_LAST_HI);

    // R2: the modulus request only rises when a new period starts
    assert_mod_rise_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(mod_hi)) |-> $past(period_end));

    // R5: active ratio changes only at a period boundary
    assert_fb_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(period_end)) |-> $stable(act_q));

endmodule

// File: rtl/synth_ref_div.sv
module synth_ref_div
    import synth_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REF_W-1:0]  next_ratio,
    input  logic [REF_W-1:0]  reset_ratio,
    output logic              term_pulse
);

    logic [REF_W-1:0] act_q;
    logic [REF_W-1:0] cnt_q;
    logic             period_end;

    assign period_end = (cnt_q == act_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q      <= reset_ratio;
            cnt_q      <= '0;
            term_pulse <= 1'b0;
        end else begin
            term_pulse <= period_end;
            cnt_q      <= period_end ? '0 : cnt_q + 1'b1;
            if (period_end)
                act_q <= next_ratio;
        end
    end

    // R3: the reference pulse lasts one cycle
    assert_ref_single_R3: assert property (@(posedge clk) disable iff (rst)
        term_pulse |=> !term_pulse);

    // R3: the count stays below the active ratio
    assert_ref_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_q < act_q);

    // R5: active reference ratio changes only at a period boundary
    assert_ref_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(period_end)) |-> $stable(act_q));

endmodule

// File: rtl/synth_div_pair.sv
module synth_div_pair
    import synth_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_sel,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [FB_W-1:0]   wr_fb_ratio,
    input  logic [REF_W-1:0]  wr_ref_ratio,
    output logic              fb_pulse,
    output logic              ref_pulse,
    output logic              mod_ctl
);

    bank_t sel_bank;
    bank_t rst_bank;

    assign rst_bank = default_bank(bank_sel ? BANK_ONE : BANK_TWO);

    synth_div_banks #(.NUM_BANKS(2)) u_banks (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_fb    (wr_fb_ratio),
        .wr_ref   (wr_ref_ratio),
        .sel      (bank_sel),
        .sel_bank (sel_bank)
    );

    synth_fb_div u_fb (
        .clk         (clk),
        .rst         (rst),
        .next_ratio  (sel_bank.fb),
        .reset_ratio (rst_bank.fb),
        .term_pulse  (fb_pulse),
        .mod_hi      (mod_ctl)
    );

    synth_ref_div u_ref (
        .clk         (clk),
        .rst         (rst),
        .next_ratio  (sel_bank.refr),
        .reset_ratio (rst_bank.refr),
        .term_pulse  (ref_pulse)
    );

    // R7: both pulses stay low through reset
    assert_rst_quiet_R7: assert property (@(posedge clk)
        $past(rst) |-> (!fb_pulse && !ref_pulse));

endmodule

// File: tb/tb_synth_div_pair.sv
module tb_synth_div_pair;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bank_sel = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_bank = 1'b0;
    logic [13:0] wr_fb = '0;
    logic [10:0] wr_ref = '0;
    logic        fb_pulse, ref_pulse, mod_ctl;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;
    string tag = "R7 reset";

    // behavioural reference state (index 1 = bank one)
    int bm [2];
    int br [2];
    int fk, fN, rk, rN;
    bit exp_fb, exp_ref;

    always #5 clk = ~clk;

    synth_div_pair dut (
        .clk(clk), .rst(rst), .bank_sel(bank_sel), .wr_en(wr_en),
        .wr_bank(wr_bank), .wr_fb_ratio(wr_fb), .wr_ref_ratio(wr_ref),
        .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .mod_ctl(mod_ctl)
    );

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            bm[1] = 10519; bm[0] = 4269;
            br[1] = 492;   br[0] = 492;
            fk = 0; rk = 0;
            fN = bank_sel ? 10519 : 4269;
            rN = 492;
            exp_fb = 0; exp_ref = 0;
        end else begin
            exp_fb = (fk == fN - 1);
            if (exp_fb) begin fk = 0; fN = bm[bank_sel]; end
            else fk++;
            exp_ref = (rk == rN - 1);
            if (exp_ref) begin rk = 0; rN = br[bank_sel]; end
            else rk++;
            if (wr_en) begin
                if (wr_fb >= 256) bm[wr_bank] = int'(wr_fb);
                if (wr_ref >= 2)  br[wr_bank] = int'(wr_ref);
            end
        end
    end

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s [%s] cycle=%0d got=%0d exp=%0d", req, tag, cycles, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            cycles++;
            check("R1 fb_pulse", int'(fb_pulse), int'(exp_fb));
            check("R2 mod_ctl", int'(mod_ctl), int'(fk < 17 * (fN % 16)));
            check("R3 ref_pulse", int'(ref_pulse), int'(exp_ref));
            if (cycles > 190000) begin
                failures++;
                $display("FAIL watchdog expired");
                done = 1;
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write(input bit bank, input int fbv, input int refv);
        wr_en = 1'b1; wr_bank = bank;
        wr_fb = 14'(fbv); wr_ref = 11'(refv);
        tick(1);
        wr_en = 1'b0;
    endtask

    initial begin
        tick(3);
        check("R7 fb_pulse in reset", int'(fb_pulse), 0);
        check("R7 ref_pulse in reset", int'(ref_pulse), 0);
        rst = 1'b0;
        tag = "R7 defaults bank one";
        tick(10600);

        tag = "R6 write bank two";
        write(1'b0, 256, 2);
        tag = "R6 out of range ignored";
        write(1'b0, 255, 1);
        tag = "R5 switch mid period";
        bank_sel = 1'b0;
        tick(11000);

        tag = "R2 swallow 15";
        write(1'b0, 271, 5);
        tick(2000);

        tag = "R4 bank one max ratios";
        write(1'b1, 16383, 2047);
        bank_sel = 1'b1;
        tick(17300);
        tag = "R4 back to bank two";
        bank_sel = 1'b0;
        tick(2000);

        tag = "R6 partial write";
        write(1'b0, 100, 7);
        tick(1500);

        tag = "R7 reset mid run";
        rst = 1'b1;
        tick(2);
        check("R7 fb_pulse in reset", int'(fb_pulse), 0);
        check("R7 ref_pulse in reset", int'(ref_pulse), 0);
        rst = 1'b0;
        tick(4500);
        tag = "R7 bank one restored";
        bank_sel = 1'b1;
        tick(11000);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule